// File: doc/BRIEF.md
# Memory barrier dependency tracker

This block holds back memory operations that are younger than an outstanding memory or write barrier. It keeps a pointer to the youngest barrier still in flight. Each barrier keeps a link to the barrier that was current when it arrived, so the live barriers form a chain from youngest to oldest. When a memory operation or a barrier is dispatched into a queue slot while a barrier is outstanding, the slot is marked as a dependent of that barrier. Its memory-dependence-ready output stays low until the barrier is released.

Barriers never issue speculatively. The commit logic presents a barrier to this block once it reaches the commit head. The block releases the barrier only when no committed stores are still waiting to write back. A release raises the ready bit of every dependent slot in a single cycle and drops the barrier from the chain.

A squash with sequence number S discards every slot younger than S. It also walks the current-barrier pointer back along the chain to the youngest surviving barrier, or to no barrier at all. Sequence numbers are assumed to increase monotonically and do not wrap.

Top module: `membar_tracker`

## Requirements
- R1: After reset, every bit of `mdep_ready` is 1 and `bar_valid` is 0.
- R2: A memory operation dispatched while no barrier is outstanding has its `mdep_ready` bit at 1 from the next cycle.
- R3: A memory operation dispatched while a barrier is outstanding, and that barrier is not being released in the same cycle, has its `mdep_ready` bit at 0 from the next cycle.
- R4: A dispatched barrier becomes the current barrier (`bar_valid`=1, `bar_slot` = its slot) in the next cycle. If another barrier was outstanding, the new barrier's own `mdep_ready` bit is 0.
- R5: A commit request with `st_pend`=1 is refused: `cmt_ack` is 0 in that cycle and no dependent becomes ready.
- R6: A commit request with `st_pend`=0 is accepted in the same cycle (`cmt_ack`=1). In the next cycle every slot that depended on that barrier has `mdep_ready`=1, and slots that depend on other barriers keep their value.
- R7: Releasing the current barrier clears `bar_valid`. Releasing an older barrier leaves `bar_valid` and `bar_slot` unchanged.
- R8: An operation dispatched in the same cycle as the release of the current barrier does not depend on that barrier.
- R9: After a squash with sequence number S, the current barrier is the youngest barrier on the chain whose sequence number is at most S, or none (`bar_valid`=0) if no such barrier exists. A released barrier counts as none.
- R10: A squash sets `mdep_ready` to 1 for every slot whose sequence number is greater than S. A dispatch presented in the same cycle as a squash is ignored.
- R11: An operation with neither the memory flag nor the barrier flag set is always ready; if both flags are set, the operation is treated as a barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_v | input | 1 | Dispatch strobe |
| disp_slot | input | SW | Queue slot of the dispatched operation |
| disp_seq | input | SEQW | Sequence number of the dispatched operation |
| disp_mem | input | 1 | Dispatched operation accesses memory |
| disp_bar | input | 1 | Dispatched operation is a memory or write barrier |
| cmt_req | input | 1 | Barrier at the commit head asks for release |
| cmt_slot | input | SW | Slot of the barrier at the commit head |
| st_pend | input | 1 | Committed stores still waiting to write back |
| sq_v | input | 1 | Squash strobe |
| sq_seq | input | SEQW | Squash sequence number; slots with a larger number are discarded |
| cmt_ack | output | 1 | Barrier release accepted this cycle |
| bar_valid | output | 1 | A barrier is outstanding |
| bar_slot | output | SW | Slot of the youngest outstanding barrier |
| mdep_ready | output | NSLOT | Per-slot memory dependence ready |

## Verification
The bound checker watches, on every cycle, the single-step effects of each event. A barrier dispatch makes that barrier current. A memory operation dispatched with no barrier outstanding is ready, and one dispatched behind a barrier is not. Releasing the current barrier empties the pointer. After a squash the pointer never names a barrier younger than S, and every discarded slot reads ready. The directed scenarios are needed for the behaviour that depends on history: a chain of several barriers, release while stores are pending, release of an older barrier while a younger one stays current, the same-cycle race between release and dispatch, and multi-step rollback that ends on a barrier which has already been released.

// File: rtl/membar_pkg.sv
package membar_pkg;

    typedef enum logic [1:0] {
        OPK_PLAIN = 2'd0,
        OPK_MEM   = 2'd1,
        OPK_BAR   = 2'd2
    } opk_e;

    // A barrier flag wins over the memory flag.
    function automatic opk_e opk_of(input logic is_mem, input logic is_bar);
        if (is_bar)      return OPK_BAR;
        else if (is_mem) return OPK_MEM;
        else             return OPK_PLAIN;
    endfunction

    // True when sequence number a is younger than b (no wrap assumed).
    function automatic logic seq_after(input logic [31:0] a, input logic [31:0] b);
        return a > b;
    endfunction

endpackage

// File: rtl/membar_chain.sv
module membar_chain
    import membar_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int SEQW  = 16,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        new_bar,
    input  logic [SW-1:0]               new_slot,
    input  logic                        rel_v,
    input  logic [SW-1:0]               rel_slot,
    input  logic                        sq_v,
    input  logic [SEQW-1:0]             sq_seq,
    input  logic [NSLOT-1:0][SEQW-1:0]  seq_r,
    output logic                        cur_v,
    output logic [SW-1:0]               cur,
    output logic                        link_v,
    output logic [SW-1:0]               link_slot
);

    logic          par_v [NSLOT];
    logic [SW-1:0] par   [NSLOT];
    logic          walk_v;
    logic [SW-1:0] walk;
    logic          nxt_v;
    logic [SW-1:0] nxt;

    // Barrier a new operation should wait on: the current one unless it leaves now.
    assign link_v    = cur_v && !(rel_v && cur == rel_slot);
    assign link_slot = cur;

    always_comb begin
        walk_v = cur_v;
        walk   = cur;
        if (sq_v) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (walk_v && seq_after(32'(seq_r[walk]), 32'(sq_seq))) begin
                    walk_v = par_v[walk];
                    walk   = par[walk];
                end
            end
        end
        nxt_v = walk_v;
        nxt   = walk;
        if (rel_v && walk == rel_slot) nxt_v = 1'b0;
        if (new_bar) begin
            nxt_v = 1'b1;
            nxt   = new_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_v <= 1'b0;
            cur   <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                par_v[i] <= 1'b0;
                par[i]   <= '0;
            end
        end else begin
            cur_v <= nxt_v;
            cur   <= nxt;
            for (int i = 0; i < NSLOT; i++) begin
                if (rel_v && par[i] == rel_slot) par_v[i] <= 1'b0;
            end
            if (new_bar) begin
                par_v[new_slot] <= link_v;
                par[new_slot]   <= cur;
            end
        end
    end

endmodule

// File: rtl/membar_deps.sv
module membar_deps #(
    parameter int NSLOT = 8,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_any,
    input  logic             disp_dep,
    input  logic [SW-1:0]    disp_slot,
    input  logic             link_v,
    input  logic [SW-1:0]    link_slot,
    input  logic             rel_v,
    input  logic [SW-1:0]    rel_slot,
    input  logic [NSLOT-1:0] kill,
    output logic [NSLOT-1:0] ready
);

    // dep[b][i]: slot i waits on the barrier held in slot b.
    logic [NSLOT-1:0] dep [NSLOT];
    logic [NSLOT-1:0] waiting;

    assign ready = ~waiting;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= '0;
            for (int b = 0; b < NSLOT; b++) dep[b] <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if ((rel_v && dep[rel_slot][i]) || kill[i]) waiting[i] <= 1'b0;
                if (disp_any && disp_slot == SW'(i)) waiting[i] <= disp_dep && link_v;
            end
            for (int b = 0; b < NSLOT; b++) begin
                for (int i = 0; i < NSLOT; i++) begin
                    if ((rel_v && rel_slot == SW'(b)) || kill[b] || kill[i] ||
                        (disp_any && (disp_slot == SW'(i) || disp_slot == SW'(b))))
                        dep[b][i] <= 1'b0;
                    if (disp_dep && link_v && link_slot == SW'(b) && disp_slot == SW'(i))
                        dep[b][i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/membar_tracker.sv
module membar_tracker
    import membar_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int SEQW  = 16,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_v,
    input  logic [SW-1:0]    disp_slot,
    input  logic [SEQW-1:0]  disp_seq,
    input  logic             disp_mem,
    input  logic             disp_bar,
    input  logic             cmt_req,
    input  logic [SW-1:0]    cmt_slot,
    input  logic             st_pend,
    input  logic             sq_v,
    input  logic [SEQW-1:0]  sq_seq,
    output logic             cmt_ack,
    output logic             bar_valid,
    output logic [SW-1:0]    bar_slot,
    output logic [NSLOT-1:0] mdep_ready
);

    opk_e                       kind;
    logic                       acc;
    logic                       rel_v;
    logic [NSLOT-1:0][SEQW-1:0] seq_r;
    logic [NSLOT-1:0]           kill;
    logic                       link_v;
    logic [SW-1:0]              link_slot;

    assign kind    = opk_of(disp_mem, disp_bar);
    assign acc     = disp_v && !sq_v;
    assign rel_v   = cmt_req && !st_pend;
    assign cmt_ack = rel_v;

    always_ff @(posedge clk) begin
        if (rst) seq_r <= '0;
        else if (acc) seq_r[disp_slot] <= disp_seq;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_kill
        assign kill[g] = sq_v && seq_after(32'(seq_r[g]), 32'(sq_seq));
    end

    membar_chain #(.NSLOT(NSLOT), .SEQW(SEQW)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .new_bar   (acc && kind == OPK_BAR),
        .new_slot  (disp_slot),
        .rel_v     (rel_v),
        .rel_slot  (cmt_slot),
        .sq_v      (sq_v),
        .sq_seq    (sq_seq),
        .seq_r     (seq_r),
        .cur_v     (bar_valid),
        .cur       (bar_slot),
        .link_v    (link_v),
        .link_slot (link_slot)
    );

    membar_deps #(.NSLOT(NSLOT)) u_deps (
        .clk       (clk),
        .rst       (rst),
        .disp_any  (acc),
        .disp_dep  (acc && kind != OPK_PLAIN),
        .disp_slot (disp_slot),
        .link_v    (link_v),
        .link_slot (link_slot),
        .rel_v     (rel_v),
        .rel_slot  (cmt_slot),
        .kill      (kill),
        .ready     (mdep_ready)
    );

endmodule

// File: rtl/membar_chk.sv
module membar_chk #(
    parameter int NSLOT = 8,
    parameter int SEQW  = 16,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       disp_v,
    input logic [SW-1:0]              disp_slot,
    input logic                       disp_mem,
    input logic                       disp_bar,
    input logic [SW-1:0]              cmt_slot,
    input logic                       sq_v,
    input logic [SEQW-1:0]            sq_seq,
    input logic                       cmt_ack,
    input logic                       bar_valid,
    input logic [SW-1:0]              bar_slot,
    input logic [NSLOT-1:0]           mdep_ready,
    input logic [NSLOT-1:0][SEQW-1:0] seq_r
);

    a_r2_free_mem_ready: assert property (@(posedge clk) disable iff (rst)
        disp_v && !sq_v && disp_mem && !disp_bar && !bar_valid
        |=> mdep_ready[$past(disp_slot)]);

    a_r3_mem_blocked: assert property (@(posedge clk) disable iff (rst)
        disp_v && !sq_v && disp_mem && !disp_bar && bar_valid &&
        !(cmt_ack && cmt_slot == bar_slot)
        |=> !mdep_ready[$past(disp_slot)]);

    a_r4_bar_current: assert property (@(posedge clk) disable iff (rst)
        disp_v && !sq_v && disp_bar
        |=> bar_valid && bar_slot == $past(disp_slot));

    a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
        cmt_ack && bar_valid && cmt_slot == bar_slot && !(disp_v && !sq_v && disp_bar)
        |=> !bar_valid);

    a_r9_pointer_survives: assert property (@(posedge clk) disable iff (rst)
        sq_v |=> !bar_valid || seq_r[bar_slot] <= $past(sq_seq));

    for (genvar g = 0; g < NSLOT; g++) begin : g_kill_chk
        a_r10_killed_ready: assert property (@(posedge clk) disable iff (rst)
            sq_v && seq_r[g] > sq_seq |=> mdep_ready[g]);
    end

endmodule

bind membar_tracker membar_chk #(.NSLOT(NSLOT), .SEQW(SEQW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_v     (disp_v),
    .disp_slot  (disp_slot),
    .disp_mem   (disp_mem),
    .disp_bar   (disp_bar),
    .cmt_slot   (cmt_slot),
    .sq_v       (sq_v),
    .sq_seq     (sq_seq),
    .cmt_ack    (cmt_ack),
    .bar_valid  (bar_valid),
    .bar_slot   (bar_slot),
    .mdep_ready (mdep_ready),
    .seq_r      (seq_r)
);

// File: tb/membar_tracker_tb.sv
module membar_tracker_tb;

    localparam int NSLOT = 8;
    localparam int SEQW  = 16;
    localparam int SW    = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             disp_v, disp_mem, disp_bar;
    logic [SW-1:0]    disp_slot;
    logic [SEQW-1:0]  disp_seq;
    logic             cmt_req, st_pend, sq_v;
    logic [SW-1:0]    cmt_slot;
    logic [SEQW-1:0]  sq_seq;
    logic             cmt_ack, bar_valid;
    logic [SW-1:0]    bar_slot;
    logic [NSLOT-1:0] mdep_ready;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    membar_tracker #(.NSLOT(NSLOT), .SEQW(SEQW)) u_dut (
        .clk(clk), .rst(rst),
        .disp_v(disp_v), .disp_slot(disp_slot), .disp_seq(disp_seq),
        .disp_mem(disp_mem), .disp_bar(disp_bar),
        .cmt_req(cmt_req), .cmt_slot(cmt_slot), .st_pend(st_pend),
        .sq_v(sq_v), .sq_seq(sq_seq),
        .cmt_ack(cmt_ack), .bar_valid(bar_valid), .bar_slot(bar_slot),
        .mdep_ready(mdep_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rdy(input int slot, input bit exp, input string req);
        chk(mdep_ready[slot] == exp, req, int'(mdep_ready[slot]), int'(exp));
    endtask

    task automatic chk_bar(input bit v, input int slot, input string req);
        chk(bar_valid == v, req, int'(bar_valid), int'(v));
        if (v) chk(bar_slot == SW'(slot), req, int'(bar_slot), slot);
    endtask

    task automatic idle();
        disp_v = 0; disp_mem = 0; disp_bar = 0; disp_slot = '0; disp_seq = '0;
        cmt_req = 0; cmt_slot = '0; st_pend = 0; sq_v = 0; sq_seq = '0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic disp(input int slot, input int seq, input bit m, input bit b);
        disp_v = 1; disp_slot = SW'(slot); disp_seq = SEQW'(seq); disp_mem = m; disp_bar = b;
        @(negedge clk);
        disp_v = 0; disp_mem = 0; disp_bar = 0;
    endtask

    task automatic commit(input int slot, input bit pend, input string req);
        cmt_req = 1; cmt_slot = SW'(slot); st_pend = pend;
        #1;
        chk(cmt_ack == !pend, req, int'(cmt_ack), int'(!pend));
        @(negedge clk);
        cmt_req = 0; st_pend = 0;
    endtask

    task automatic squash(input int seq);
        sq_v = 1; sq_seq = SEQW'(seq);
        @(negedge clk);
        sq_v = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(mdep_ready == '1, "R1", int'(mdep_ready), 255);
        chk_bar(0, 0, "R1");
    endtask

    task automatic t_no_barrier();
        do_reset();
        disp(0, 1, 0, 0);
        chk_rdy(0, 1, "R11");
        disp(1, 2, 1, 0);
        chk_rdy(1, 1, "R2");
        chk_bar(0, 0, "R2");
    endtask

    task automatic t_chain_release();
        do_reset();
        disp(0, 10, 0, 1);
        chk_bar(1, 0, "R4");
        chk_rdy(0, 1, "R4");
        disp(1, 11, 1, 0);
        chk_rdy(1, 0, "R3");
        disp(2, 12, 1, 1);               // both flags: treated as barrier (R11)
        chk_bar(1, 2, "R11");
        chk_rdy(2, 0, "R4");
        disp(3, 13, 1, 0);
        chk_rdy(3, 0, "R3");
        commit(0, 1, "R5");
        chk_rdy(1, 0, "R5");
        chk_rdy(2, 0, "R5");
        commit(0, 0, "R6");
        chk_rdy(1, 1, "R6");
        chk_rdy(2, 1, "R6");
        chk_rdy(3, 0, "R6");
        chk_bar(1, 2, "R7");
        squash(11);                      // slots 2,3 discarded; slot 2's parent released
        chk_bar(0, 0, "R9");
        chk_rdy(3, 1, "R10");
        chk_rdy(1, 1, "R10");
    endtask

    task automatic t_same_cycle();
        do_reset();
        disp(0, 5, 0, 1);
        cmt_req = 1; cmt_slot = 3'd0; st_pend = 0;
        disp(1, 6, 1, 0);
        cmt_req = 0;
        chk_rdy(1, 1, "R8");
        chk_bar(0, 0, "R7");
        disp(2, 7, 0, 1);
        disp(3, 8, 0, 1);
        chk_rdy(3, 0, "R4");
        commit(2, 0, "R6");
        chk_rdy(3, 1, "R6");
        chk_bar(1, 3, "R7");
    endtask

    task automatic t_squash_walk();
        do_reset();
        disp(0, 20, 0, 1);
        disp(1, 21, 1, 0);
        disp(2, 22, 0, 1);
        disp(3, 23, 1, 0);
        disp(4, 24, 0, 1);
        chk_bar(1, 4, "R4");
        squash(23);
        chk_bar(1, 2, "R9");
        chk_rdy(3, 0, "R10");
        chk_rdy(4, 1, "R10");
        squash(21);
        chk_bar(1, 0, "R9");
        chk_rdy(3, 1, "R10");
        chk_rdy(1, 0, "R10");
        disp_v = 1; disp_slot = 3'd5; disp_seq = 16'd30; disp_bar = 1;
        squash(19);
        disp_v = 0; disp_bar = 0;
        chk_bar(0, 0, "R9");
        chk_rdy(1, 1, "R10");
        chk_rdy(5, 1, "R10");
        disp(6, 31, 1, 0);               // no barrier: dispatch behind nothing
        chk_rdy(6, 1, "R10");
    endtask

    initial begin
        t_reset();
        t_no_barrier();
        t_chain_release();
        t_same_cycle();
        t_squash_walk();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule